// File: doc/BRIEF.md
# Chip-Select Pulse Clock Calibrator

This block sets the period of an internal PWM clock from a timing pulse supplied by a host controller. The host first issues a calibration command, which reaches the block as a one-cycle strobe. The block then times the next low pulse on the active-low chip-select line, in system-clock cycles. A pulse that lies inside the allowed window sets the internal clock period to the measured length divided by 128. A pulse outside the window leaves the period as it was. That is the last accepted value, or the built-in default when no calibration has yet been accepted.

The calibrated period drives a clock-enable generator, which emits a one-cycle tick once every period. Downstream PWM logic uses that tick in place of a free-running clock. No data flows through the block, so it has no valid/ready stream: every pin is plain control or status, sampled on the rising clock edge. The chip-select line is assumed to be synchronous to `clk`.

Top module: `csel_clk_calibrator`

## Requirements
- R1: After reset, `period_o` equals DEF_PERIOD (12 by default), `calibrated_o` is 0, `armed_o` is 0, and the tick generator restarts from zero.
- R2: A high cycle on `cal_cmd_i` while idle sets `armed_o` to 1 from the next cycle. A chip-select low pulse that arrives while the block is not armed leaves `period_o` and `calibrated_o` unchanged.
- R3: While armed, the pulse length L is the number of rising clock edges at which `cs_n_i` is sampled low, counted from the first low sample after a high sample up to the edge where it is sampled high again. If MIN_LEN ≤ L ≤ MAX_LEN, then `period_o` becomes L >> 7 (L divided by 128, rounded down) at that edge, and `calibrated_o` becomes 1.
- R4: A pulse with L < MIN_LEN (256 by default) is rejected: `period_o` keeps its previous value.
- R5: When the count reaches MAX_LEN (2048 by default) and `cs_n_i` is still sampled low, the measurement ends at once as a rejection. `armed_o` drops while chip select is still low, and `period_o` is unchanged.
- R6: A rejection before any accepted calibration keeps `period_o` at DEF_PERIOD and `calibrated_o` at 0.
- R7: Arming is spent by one measured pulse, whether it was accepted or rejected. `armed_o` is 0 from the cycle after the measurement ends, and a second pulse needs a new command.
- R8: `tick_o` is a single-cycle pulse that repeats every `period_o` cycles. Consecutive ticks are exactly `period_o` cycles apart.
- R9: A `cal_cmd_i` strobe that arrives during a measurement has no effect. The measurement completes normally, and arming is still cleared afterwards.
- R10: Both window limits are inclusive. L = MIN_LEN gives period 2, and L = MAX_LEN gives period 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_cmd_i | input | 1 | One-cycle strobe from the command decoder that arms calibration |
| cs_n_i | input | 1 | Active-low chip select carrying the timing pulse |
| armed_o | output | 1 | High while armed or measuring |
| calibrated_o | output | 1 | High once any pulse has been accepted |
| period_o | output | PER_W (5) | Current internal clock period, in system cycles |
| tick_o | output | 1 | Clock-enable pulse, one per period |

## Verification
The assertions check the per-cycle properties on every cycle:
- The period changes only at an accepted measurement end, and then equals the length shifted right by seven.
- `calibrated_o` never falls, and the default period holds while the block is uncalibrated.
- The counter never passes MAX_LEN.
- Arming is gone in the cycle after any measurement end.
- A tick is never followed by another tick in the next cycle.

Some behaviour needs whole scenarios, so only the bench can show it:
- Which pulse lengths are accepted, including the exact inclusive limits.
- That an unarmed pulse or a strobe in mid-measurement is ignored.
- That an overlong pulse is cut off while chip select is still low.
- That the gap between ticks matches the period after each recalibration.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } cal_state_e;

  // Divide ratio between the measured pulse and one internal period
  localparam int unsigned DIV_SHIFT = 7;
endpackage

// File: rtl/cal_pulse_meter.sv
module cal_pulse_meter
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned MIN_LEN = 256,
  parameter int unsigned MAX_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             cs_n_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [CNT_W-1:0] len_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] MinL = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MaxL = CNT_W'(MAX_LEN);

  cal_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cs_q;
  logic             fall;
  logic             overflow;

  assign fall     = cs_q & ~cs_n_i;
  assign overflow = (st_q == ST_MEAS) && !cs_n_i && (cnt_q == MaxL);
  assign done_o   = (st_q == ST_MEAS) && (cs_n_i || overflow);
  assign ok_o     = done_o && cs_n_i && (cnt_q >= MinL);
  assign len_o    = cnt_q;
  assign armed_o  = (st_q != ST_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (arm_i) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (fall) begin
          st_d  = ST_MEAS;
          cnt_d = CNT_W'(1);
        end
      end
      ST_MEAS: begin
        if (done_o) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cs_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cs_q  <= cs_n_i;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MaxL);

  // R7
  arm_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !armed_o);

  // R2
  arm_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && arm_i) |=> armed_o);
endmodule

// File: rtl/cal_period_reg.sv
module cal_period_reg
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned PER_W      = 5,
  parameter int unsigned DEF_PERIOD = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             ok_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [PER_W-1:0] period_o,
  output logic             cal_o
);
  logic [PER_W-1:0] period_q;
  logic             cal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= PER_W'(DEF_PERIOD);
      cal_q    <= 1'b0;
    end else if (done_i && ok_i) begin
      period_q <= len_i[CNT_W-1:DIV_SHIFT];
      cal_q    <= 1'b1;
    end
  end

  assign period_o = period_q;
  assign cal_o    = cal_q;

  // R4
  hold_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i && ok_i) |=> $stable(period_q));

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && ok_i) |=> (CNT_W'(period_q) == ($past(len_i) >> DIV_SHIFT)));

  // R6
  default_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_q |-> (period_q == PER_W'(DEF_PERIOD)));

  // R3
  cal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cal_q));
endmodule

// File: rtl/cal_tick_gen.sv
module cal_tick_gen #(
  parameter int unsigned PER_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   nxt;

  assign nxt    = (PER_W+1)'(cnt_q) + (PER_W+1)'(1);
  assign tick_o = (nxt >= (PER_W+1)'(period_i));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= nxt[PER_W-1:0];
  end

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (period_i >= PER_W'(2))) |=> !tick_o);
endmodule

// File: rtl/csel_clk_calibrator.sv
module csel_clk_calibrator
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned MIN_LEN    = 256,
  parameter int unsigned MAX_LEN    = 2048,
  parameter int unsigned DEF_PERIOD = 12,
  parameter int unsigned PER_W      = CNT_W - DIV_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_cmd_i,
  input  logic             cs_n_i,
  output logic             armed_o,
  output logic             calibrated_o,
  output logic [PER_W-1:0] period_o,
  output logic             tick_o
);
  logic             done;
  logic             ok;
  logic [CNT_W-1:0] len;
  logic [PER_W-1:0] period;

  cal_pulse_meter #(
    .CNT_W  (CNT_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (cal_cmd_i),
    .cs_n_i (cs_n_i),
    .done_o (done),
    .ok_o   (ok),
    .len_o  (len),
    .armed_o(armed_o)
  );

  cal_period_reg #(
    .CNT_W     (CNT_W),
    .PER_W     (PER_W),
    .DEF_PERIOD(DEF_PERIOD)
  ) u_preg (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .ok_i    (ok),
    .len_i   (len),
    .period_o(period),
    .cal_o   (calibrated_o)
  );

  cal_tick_gen #(
    .PER_W(PER_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .period_i(period),
    .tick_o  (tick_o)
  );

  assign period_o = period;
endmodule

// File: tb/sim_csel_clk_calibrator.sv
module sim_csel_clk_calibrator;
  localparam int MIN_L = 256;
  localparam int MAX_L = 2048;
  localparam int DEF_P = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_cmd_i = 1'b0;
  logic       cs_n_i = 1'b1;
  logic       armed_o;
  logic       calibrated_o;
  logic [4:0] period_o;
  logic       tick_o;

  int n_chk = 0;
  int n_err = 0;
  int exp_per = DEF_P;
  bit exp_cal = 1'b0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  csel_clk_calibrator u0 (
    .clk(clk), .rst_n(rst_n), .cal_cmd_i(cal_cmd_i), .cs_n_i(cs_n_i),
    .armed_o(armed_o), .calibrated_o(calibrated_o),
    .period_o(period_o), .tick_o(tick_o)
  );

  function automatic bit accepts(int len);
    return (len >= MIN_L) && (len <= MAX_L);
  endfunction

  function automatic int per_of(int len);
    return len / 128;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk) cal_cmd_i = 1'b1;
    @(negedge clk) cal_cmd_i = 1'b0;
  endtask

  task automatic pulse(int len, bit armed);
    @(negedge clk) cs_n_i = 1'b0;
    repeat (len) @(negedge clk);
    cs_n_i = 1'b1;
    if (armed && accepts(len)) begin
      exp_per = per_of(len);
      exp_cal = 1'b1;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_gap(string req);
    int gap = 0;
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!tick_o && gap < 64) begin
      @(negedge clk);
      gap++;
    end
    check(req, gap, exp_per);
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 period", period_o, DEF_P);
    check("R1 calibrated", calibrated_o, 0);
    check("R1 armed", armed_o, 0);
    check_gap("R8 default gap");

    // R2 unarmed pulse ignored
    pulse(1000, 1'b0);
    check("R2 unarmed period", period_o, DEF_P);
    check("R2 unarmed cal", calibrated_o, 0);
    arm();
    check("R2 armed", armed_o, 1);

    // R4 / R6 short pulse before any calibration
    pulse(MIN_L - 1, 1'b1);
    check("R6 period", period_o, DEF_P);
    check("R6 calibrated", calibrated_o, 0);
    check("R7 armed cleared", armed_o, 0);

    // R10 lower limit
    arm();
    pulse(MIN_L, 1'b1);
    check("R10 min", period_o, 2);
    check("R3 calibrated", calibrated_o, 1);
    check_gap("R8 gap min");

    // R10 upper limit
    arm();
    pulse(MAX_L, 1'b1);
    check("R10 max", period_o, 16);

    // R3 typical value
    arm();
    pulse(1000, 1'b1);
    check("R3 period 1000", period_o, 7);

    // R7 second pulse without re-arm
    pulse(600, 1'b0);
    check("R7 no rearm", period_o, 7);

    // R5 overflow cut-off while still low
    arm();
    @(negedge clk) cs_n_i = 1'b0;
    repeat (MAX_L + 3) @(negedge clk);
    check("R5 armed drop", armed_o, 0);
    cs_n_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 period kept", period_o, 7);

    // R4 short after calibration
    arm();
    pulse(100, 1'b1);
    check("R4 short kept", period_o, 7);

    // R9 command in mid-measurement
    arm();
    @(negedge clk) cs_n_i = 1'b0;
    repeat (200) @(negedge clk);
    cal_cmd_i = 1'b1;
    @(negedge clk) cal_cmd_i = 1'b0;
    repeat (199) @(negedge clk);
    cs_n_i = 1'b1;
    exp_per = per_of(400);
    repeat (2) @(negedge clk);
    check("R9 period", period_o, exp_per);
    check("R9 armed", armed_o, 0);

    // random mix
    for (int i = 0; i < 24; i++) begin
      int len = 64 + int'($urandom_range(2400));
      bit do_arm = ($urandom_range(9) < 8);
      if (do_arm) arm();
      pulse(len, do_arm);
      check("R3 random period", period_o, exp_per);
      check("R7 random armed", armed_o, 0);
      check("R6 random cal", calibrated_o, exp_cal);
      if (i % 6 == 0) check_gap("R8 random gap");
    end
    finish_run();
  end
endmodule